// File: doc/BRIEF.md
# Latched One-of-Sixteen Line Decoder

This block turns a small binary address into a one-of-N select vector. A strobe controls a register that holds the address. While the strobe is high, the register takes a new address on every clock edge. While the strobe is low, the register keeps the last address it took, so the address bus can change without moving the selection.

An inhibit input sends every line to its idle level at once. The inhibit does not disturb the stored address, so the earlier selection comes back as soon as the inhibit is released. A parameter fixes the polarity: the selected line is either driven high with the others low, or driven low with the others high.

Top module: `addr_latch_decoder`

## Requirements
- R1: While `strobe` is 1, each rising clock edge loads `sel_in` into the address register. The new selection is visible on `lines_out` right after that edge.
- R2: While `strobe` is 0, changes on `sel_in` have no effect on `lines_out`.
- R3: Bit 0 of `sel_in` is the least significant bit of the address. Address value k selects line k (`lines_out[k]`), so 0000 selects line 0 and 1111 selects line 15.
- R4: While `inhibit` is 0, exactly one line is at its active level.
- R5: With `ACTIVE_LOW` = 0, the selected line is 1 and the others are 0. With `ACTIVE_LOW` = 1, the selected line is 0 and the others are 1.
- R6: While `inhibit` is 1, every line is at its idle level in the same cycle, whatever the address. Idle is all 0 for `ACTIVE_LOW` = 0 and all 1 for `ACTIVE_LOW` = 1.
- R7: The inhibit does not change the stored address. Releasing it brings back the selection that was stored before.
- R8: A synchronous reset clears the stored address to 0, so line 0 is selected after reset.
- R9: Reset takes priority over `strobe`. An address presented during reset is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_in | input | SEL_W (4) | Address to be stored, bit 0 least significant |
| strobe | input | 1 | 1: register follows `sel_in` at each edge; 0: register holds |
| inhibit | input | 1 | 1: every output line idle |
| lines_out | output | 2**SEL_W (16) | Decoded select lines |

## Verification
An address presented with the strobe high reaches the lines one clock edge later, because one register lies on that path. The inhibit has no register on its path, so it acts in the same cycle. The bench keeps its own model of the stored address, which it updates at each rising edge from the values driven a little after the previous edge. It compares both polarity instances against this model at every falling edge, so each result is sampled in the cycle it is due and away from the edge where it is produced.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

   // Output polarity choices
   typedef enum logic {
      POL_HIGH = 1'b0,
      POL_LOW  = 1'b1
   } polarity_e;

   localparam int MAX_SEL_W = 8;

endpackage

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [SEL_W-1:0] d,
   output logic [SEL_W-1:0] q
);

   // Reset wins over load; the register holds when load is low
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/onehot_expand.sv
module onehot_expand #(
   parameter int SEL_W = 4,
   localparam int N_OUT = 2 ** SEL_W
) (
   input  logic [SEL_W-1:0] addr,
   output logic [N_OUT-1:0] hit
);

   // One comparator per output line
   for (genvar gi = 0; gi < N_OUT; gi++) begin : g_line
      assign hit[gi] = (addr == SEL_W'(gi));
   end

endmodule

// File: rtl/line_driver.sv
module line_driver
   import addr_dec_pkg::*;
#(
   parameter int        N_OUT    = 16,
   parameter polarity_e POLARITY = POL_HIGH
) (
   input  logic [N_OUT-1:0] hit,
   input  logic             inhibit,
   output logic [N_OUT-1:0] lines
);

   // The polarity is fixed at elaboration, so only one variant is built
   if (POLARITY == POL_LOW) begin : g_low
      assign lines = inhibit ? {N_OUT{1'b1}} : ~hit;
   end else begin : g_high
      assign lines = inhibit ? {N_OUT{1'b0}} : hit;
   end

endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
   import addr_dec_pkg::*;
#(
   parameter int SEL_W      = 4,
   parameter bit ACTIVE_LOW = 1'b0,
   localparam int N_OUT = 2 ** SEL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             strobe,
   input  logic             inhibit,
   output logic [N_OUT-1:0] lines_out
);

   localparam polarity_e POL = ACTIVE_LOW ? POL_LOW : POL_HIGH;

   initial begin
      assert (SEL_W >= 1 && SEL_W <= MAX_SEL_W)
         else $error("addr_latch_decoder: SEL_W out of range");
   end

   logic [SEL_W-1:0] addr_q;
   logic [N_OUT-1:0] hit;

   addr_hold_reg #(.SEL_W(SEL_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (strobe),
      .d    (sel_in),
      .q    (addr_q)
   );

   onehot_expand #(.SEL_W(SEL_W)) u_expand (
      .addr (addr_q),
      .hit  (hit)
   );

   line_driver #(.N_OUT(N_OUT), .POLARITY(POL)) u_drive (
      .hit     (hit),
      .inhibit (inhibit),
      .lines   (lines_out)
   );

endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
   parameter int SEL_W      = 4,
   parameter bit ACTIVE_LOW = 1'b0,
   localparam int N_OUT = 2 ** SEL_W
) (
   input logic             clk,
   input logic             rst,
   input logic [SEL_W-1:0] sel_in,
   input logic             strobe,
   input logic             inhibit,
   input logic [N_OUT-1:0] lines_out
);

   logic [N_OUT-1:0] act;
   assign act = ACTIVE_LOW ? ~lines_out : lines_out;

   AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      strobe |=> (inhibit || act[$past(sel_in)])); // R1

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> ($stable(lines_out) || !$stable(inhibit))); // R2

   AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      !inhibit |-> ($countones(act) == 1)); // R4

   AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (rst)
      inhibit |-> (act == '0)); // R6

endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(
   .SEL_W(SEL_W), .ACTIVE_LOW(ACTIVE_LOW)
) chk_i (.*);

// File: tb/addr_latch_decoder_tb_top.sv
module addr_latch_decoder_tb_top;

   localparam int CLK_P = 10;
   localparam int SW    = 4;
   localparam int NO    = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [SW-1:0] sel_in = '0;
   logic          strobe = 1'b0;
   logic          inhibit = 1'b0;
   logic [NO-1:0] out_hi;
   logic [NO-1:0] out_lo;

   int    n_chk = 0;
   int    n_fail = 0;
   int    ref_addr = 0;
   string tag = "R8";

   always #(CLK_P/2) clk = ~clk;

   addr_latch_decoder #(.SEL_W(SW), .ACTIVE_LOW(1'b0)) dut_i (
      .clk(clk), .rst(rst), .sel_in(sel_in), .strobe(strobe),
      .inhibit(inhibit), .lines_out(out_hi));

   addr_latch_decoder #(.SEL_W(SW), .ACTIVE_LOW(1'b1)) dut_lo_i (
      .clk(clk), .rst(rst), .sel_in(sel_in), .strobe(strobe),
      .inhibit(inhibit), .lines_out(out_lo));

   // Behavioural model of the stored address
   always @(posedge clk) begin
      if (rst) ref_addr <= 0;
      else if (strobe) ref_addr <= int'(sel_in);
   end

   task automatic check(input bit ok, input string req,
                        input logic [NO-1:0] act, input logic [NO-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // Compare against the model at every falling edge
   always @(negedge clk) begin
      logic [NO-1:0] e_hi;
      e_hi = inhibit ? '0 : (NO'(1) << ref_addr);
      check(out_hi === e_hi, tag, out_hi, e_hi);
      check(out_lo === ~e_hi, tag, out_lo, ~e_hi);
      if (!inhibit) begin
         check($countones(out_hi) == 1, "R4", out_hi, e_hi);
         check($countones(~out_lo) == 1, "R4", out_lo, ~e_hi);
      end
   end

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #2;
      end
   endtask

   initial begin
      #(CLK_P * 5000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R9: strobe and an address during reset are not stored
      tag = "R9"; strobe = 1'b1; sel_in = 4'd5;
      step(3);
      // R8: after reset, line 0 selected
      rst = 1'b0; strobe = 1'b0; tag = "R8";
      step(2);
      // R3 / R5: sweep every address in both polarities
      tag = "R3"; strobe = 1'b1;
      for (int a = 0; a < NO; a++) begin
         sel_in = SW'(a);
         step(1);
      end
      tag = "R5";
      for (int a = NO - 1; a >= 0; a--) begin
         sel_in = SW'(a);
         step(1);
      end
      // R1: back-to-back loads
      tag = "R1";
      sel_in = 4'd3; step(1);
      sel_in = 4'd12; step(1);
      sel_in = 4'd7; step(1);
      // R2: hold while strobe is low and the address bus moves
      sel_in = 4'd9; step(1);
      tag = "R2"; strobe = 1'b0;
      for (int a = 0; a < NO; a++) begin
         sel_in = SW'(a);
         step(1);
      end
      // R6: inhibit forces idle lines regardless of address
      tag = "R6"; inhibit = 1'b1;
      for (int a = 0; a < 4; a++) begin
         sel_in = SW'(a * 5);
         step(1);
      end
      // R7: releasing inhibit restores the stored line 9
      tag = "R7"; inhibit = 1'b0;
      step(2);
      // R6/R1: load under inhibit, then release shows the new address
      tag = "R6"; inhibit = 1'b1; strobe = 1'b1; sel_in = 4'd14;
      step(1);
      strobe = 1'b0;
      step(1);
      tag = "R7"; inhibit = 1'b0;
      step(2);
      // R8: reset again clears to line 0
      tag = "R8"; rst = 1'b1;
      step(1);
      rst = 1'b0;
      step(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule